// File: doc/BRIEF.md
# Interrupt status and mask controller

This block holds the sticky fault flags of a supply and driver monitor and turns them into a single interrupt request for a CPU. Low-voltage and high-voltage conditions each set a status flag. Two overcurrent conditions, one for the driver supply and one for the half-bridge, each set their own sub-flag. The OR of those two sub-flags appears as one overcurrent summary bit. A LIN event flag and a high-temperature flag come in from outside as ready-made levels.

Software reads and clears the flags through a small synchronous register port. A flag is cleared by writing 1 to its bit. Such a clear has no effect while the fault that set the flag is still present, so an event cannot be lost. A mask register holds one enable bit per source. The interrupt output is a registered OR over every source whose flag and enable are both set.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all four fault flags, all five enable bits, `irq_req` and `reg_rdata` are 0.
- R2: On every clock edge where `low_volt_cond` is high, the low-voltage flag becomes set, and it stays set after the condition drops. The flag reads at address 0x03 bit 3. The high-voltage flag behaves the same way, with `high_volt_cond`, at address 0x03 bit 2.
- R3: Writing 0x03 with bit 3 (or bit 2) at 1 clears the low-voltage (or high-voltage) flag on that edge. A 0 in that bit leaves the flag unchanged.
- R4: If a flag's condition is high on the same edge as a clearing write to that flag, the flag stays set. Setting takes priority over clearing.
- R5: Address 0x03 bit 1 reads the OR of the two overcurrent sub-flags. Writing to bit 1 of 0x03 has no effect on either sub-flag.
- R6: Address 0x05 bit 1 is the driver-supply overcurrent sub-flag, set by `drv_oc_cond`. Address 0x05 bit 0 is the half-bridge sub-flag, set by `bridge_oc_cond`. Each sub-flag is cleared only by writing 1 to its own bit at 0x05, and that clear is blocked while its condition is high.
- R7: The mask register at 0x04 holds the enables: bit 5 LIN, bit 4 high temperature, bit 3 low voltage, bit 2 high voltage, bit 1 overcurrent. All five are read/write. Bits 7, 6 and 0 read as 0.
- R8: One clock edge after the flags and enables take their values, `irq_req` equals the OR of (LIN input AND LIN enable), (high-temperature input AND its enable), (low-voltage flag AND its enable), (high-voltage flag AND its enable) and (overcurrent summary AND its enable).
- R9: When `reg_re` is high at an edge, `reg_rdata` shows after that edge the register contents as they were before the edge. It shows 0 after any edge where `reg_re` is low, and 0 for any address other than 0x03, 0x04 and 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| low_volt_cond | input | 1 | Low-voltage condition, already synchronized |
| high_volt_cond | input | 1 | High-voltage condition, already synchronized |
| drv_oc_cond | input | 1 | Driver-supply overcurrent condition |
| bridge_oc_cond | input | 1 | Half-bridge overcurrent condition |
| lin_flag_in | input | 1 | LIN event flag from outside the block |
| hot_flag_in | input | 1 | High-temperature flag from outside the block |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle that each flag is set after an edge where its condition was high, that it holds without a clear, that it drops after an unblocked clear, that the mask changes only on writes to it, that an active enabled source raises the request, that an empty mask keeps it low, and that idle read cycles return zero. Only the bench's scenarios can show the full register map. This includes which write bit clears which flag, that the overcurrent summary cannot be cleared through its own register, and that reserved mask bits read as zero. A sweep over all 32 mask values against all 32 source patterns shows the exact OR-of-AND mapping and its one-edge latency.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;

    localparam int REG_W = 8;

    localparam int STAT_ADDR = 'h03;
    localparam int MASK_ADDR = 'h04;
    localparam int SYS_ADDR  = 'h05;

    // bit positions in the status register
    localparam int STAT_LOW_BIT  = 3;
    localparam int STAT_HIGH_BIT = 2;
    localparam int STAT_OC_BIT   = 1;

    // bit positions in the system status register
    localparam int SYS_DRV_BIT    = 1;
    localparam int SYS_BRIDGE_BIT = 0;

    // fault flag indices
    localparam int N_FLAGS    = 4;
    localparam int F_LOW      = 0;
    localparam int F_HIGH     = 1;
    localparam int F_DRV_OC   = 2;
    localparam int F_BRIDGE_OC = 3;

    // one bit per interrupt source; order matches mask bits 5..1
    typedef struct packed {
        logic lin;
        logic hot;
        logic low;
        logic high;
        logic oc;
    } src_t;

    localparam int N_SRC = $bits(src_t);

    function automatic logic [REG_W-1:0] mask_view(input src_t en);
        return {2'b00, en, 1'b0};
    endfunction

    function automatic logic [REG_W-1:0] stat_view(input logic [N_FLAGS-1:0] f);
        logic [REG_W-1:0] v;
        v = '0;
        v[STAT_LOW_BIT]  = f[F_LOW];
        v[STAT_HIGH_BIT] = f[F_HIGH];
        v[STAT_OC_BIT]   = f[F_DRV_OC] | f[F_BRIDGE_OC];
        return v;
    endfunction

    function automatic logic [REG_W-1:0] sys_view(input logic [N_FLAGS-1:0] f);
        logic [REG_W-1:0] v;
        v = '0;
        v[SYS_DRV_BIT]    = f[F_DRV_OC];
        v[SYS_BRIDGE_BIT] = f[F_BRIDGE_OC];
        return v;
    endfunction

endpackage

// File: rtl/sticky_flag.sv
module sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    input  logic clr,
    output logic flag
);

    // set wins over clear, so a clear during a live fault is ignored
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (cond)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    p_set_on_cond_r2: assert property (@(posedge clk) disable iff (rst)
        cond |=> flag);

    p_hold_no_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    p_clear_blocked_r4: assert property (@(posedge clk) disable iff (rst)
        (cond && clr) |=> flag);

    p_clear_works_r3: assert property (@(posedge clk) disable iff (rst)
        (clr && !cond) |=> !flag);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> !flag);

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import fault_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  src_t wr_val,
    output src_t en
);

    always_ff @(posedge clk) begin
        if (rst)
            en <= '0;
        else if (wr)
            en <= wr_val;
    end

    p_mask_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(en));

    p_mask_reset_r1: assert property (@(posedge clk)
        rst |=> (en == '0));

endmodule

// File: rtl/irq_merge.sv
module irq_merge
    import fault_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  src_t active,
    input  src_t en,
    output logic irq
);

    src_t hit;

    always_comb hit = active & en;

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= |hit;
    end

    p_no_enable_no_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |=> !irq);

    p_enabled_low_raises_r8: assert property (@(posedge clk) disable iff (rst)
        (active.low && en.low) |=> irq);

    p_enabled_oc_raises_r8: assert property (@(posedge clk) disable iff (rst)
        (active.oc && en.oc) |=> irq);

    p_irq_reset_r1: assert property (@(posedge clk)
        rst |=> !irq);

endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
    import fault_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              low_volt_cond,
    input  logic              high_volt_cond,
    input  logic              drv_oc_cond,
    input  logic              bridge_oc_cond,
    input  logic              lin_flag_in,
    input  logic              hot_flag_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_req
);

    logic sel_stat, sel_mask, sel_sys;
    logic [N_FLAGS-1:0] cond_v;
    logic [N_FLAGS-1:0] clr_v;
    logic [N_FLAGS-1:0] flag_v;
    src_t mask_en;
    src_t mask_wr_val;
    src_t active;
    logic [REG_W-1:0] rd_mux;
    logic [1:0] unused_wdata_bits;

    assign unused_wdata_bits = reg_wdata[7:6];

    always_comb begin
        sel_stat = (reg_addr == ADDR_W'(STAT_ADDR));
        sel_mask = (reg_addr == ADDR_W'(MASK_ADDR));
        sel_sys  = (reg_addr == ADDR_W'(SYS_ADDR));
    end

    always_comb begin
        cond_v              = '0;
        cond_v[F_LOW]       = low_volt_cond;
        cond_v[F_HIGH]      = high_volt_cond;
        cond_v[F_DRV_OC]    = drv_oc_cond;
        cond_v[F_BRIDGE_OC] = bridge_oc_cond;

        clr_v               = '0;
        clr_v[F_LOW]        = reg_we & sel_stat & reg_wdata[STAT_LOW_BIT];
        clr_v[F_HIGH]       = reg_we & sel_stat & reg_wdata[STAT_HIGH_BIT];
        clr_v[F_DRV_OC]     = reg_we & sel_sys  & reg_wdata[SYS_DRV_BIT];
        clr_v[F_BRIDGE_OC]  = reg_we & sel_sys  & reg_wdata[SYS_BRIDGE_BIT];
    end

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        sticky_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .cond (cond_v[i]),
            .clr  (clr_v[i]),
            .flag (flag_v[i])
        );
    end

    assign mask_wr_val = src_t'(reg_wdata[5:1]);

    irq_mask_reg u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_we & sel_mask),
        .wr_val (mask_wr_val),
        .en     (mask_en)
    );

    always_comb begin
        active.lin  = lin_flag_in;
        active.hot  = hot_flag_in;
        active.low  = flag_v[F_LOW];
        active.high = flag_v[F_HIGH];
        active.oc   = flag_v[F_DRV_OC] | flag_v[F_BRIDGE_OC];
    end

    irq_merge u_merge (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .en     (mask_en),
        .irq    (irq_req)
    );

    always_comb begin
        rd_mux = '0;
        if (sel_stat)
            rd_mux = stat_view(flag_v);
        else if (sel_mask)
            rd_mux = mask_view(mask_en);
        else if (sel_sys)
            rd_mux = sys_view(flag_v);
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (reg_re)
            reg_rdata <= rd_mux;
        else
            reg_rdata <= '0;
    end

    p_rdata_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !reg_re |=> (reg_rdata == '0));

    p_mask_reserved_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_re && sel_mask) |=> (reg_rdata[7] == 1'b0 && reg_rdata[6] == 1'b0 && reg_rdata[0] == 1'b0));

    p_oc_summary_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_re && sel_stat && (flag_v[F_DRV_OC] || flag_v[F_BRIDGE_OC])) |=> reg_rdata[STAT_OC_BIT]);

    p_rdata_reset_r1: assert property (@(posedge clk)
        rst |=> (reg_rdata == '0));

endmodule

// File: tb/fault_irq_ctrl_test.sv
module fault_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       low_volt_cond = 1'b0;
    logic       high_volt_cond = 1'b0;
    logic       drv_oc_cond = 1'b0;
    logic       bridge_oc_cond = 1'b0;
    logic       lin_flag_in = 1'b0;
    logic       hot_flag_in = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic       reg_re = 1'b0;
    logic [7:0] reg_rdata;
    logic       irq_req;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fault_irq_ctrl uut (
        .clk            (clk),
        .rst            (rst),
        .low_volt_cond  (low_volt_cond),
        .high_volt_cond (high_volt_cond),
        .drv_oc_cond    (drv_oc_cond),
        .bridge_oc_cond (bridge_oc_cond),
        .lin_flag_in    (lin_flag_in),
        .hot_flag_in    (hot_flag_in),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_we         (reg_we),
        .reg_re         (reg_re),
        .reg_rdata      (reg_rdata),
        .irq_req        (irq_req)
    );

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, actual, expected);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        step();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a; reg_re = 1'b1;
        step();
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(tag, int'(d), int'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        @(negedge clk);
        step();
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 irq", int'(irq_req), 0);
        check("R1 rdata", int'(reg_rdata), 0);
        rd_check("R1 stat", 8'h03, 8'h00);
        rd_check("R1 mask", 8'h04, 8'h00);
        rd_check("R1 sys", 8'h05, 8'h00);

        // R7: mask bits and reserved bits
        wr(8'h04, 8'hFF);
        rd_check("R7 mask all", 8'h04, 8'h3E);
        wr(8'h04, 8'h14);
        rd_check("R7 mask partial", 8'h04, 8'h14);
        wr(8'h04, 8'h00);
        rd_check("R7 mask clear", 8'h04, 8'h00);

        // R9: unmapped address and idle read
        rd_check("R9 unmapped", 8'h07, 8'h00);
        low_volt_cond = 1'b1; step(); low_volt_cond = 1'b0;
        rd(8'h03, d);
        step();
        check("R9 idle rdata", int'(reg_rdata), 0);

        // R2, R3: low-voltage flag
        rd_check("R2 low sticky", 8'h03, 8'h08);
        wr(8'h03, 8'h00);
        rd_check("R3 write zero", 8'h03, 8'h08);
        wr(8'h03, 8'h04);
        rd_check("R3 other bit", 8'h03, 8'h08);
        wr(8'h03, 8'h08);
        rd_check("R3 low cleared", 8'h03, 8'h00);

        // R2, R3: high-voltage flag
        high_volt_cond = 1'b1; step(); high_volt_cond = 1'b0;
        rd_check("R2 high sticky", 8'h03, 8'h04);
        wr(8'h03, 8'h08);
        rd_check("R3 high wrong bit", 8'h03, 8'h04);
        wr(8'h03, 8'h04);
        rd_check("R3 high cleared", 8'h03, 8'h00);

        // R4: clear blocked while condition is live
        low_volt_cond = 1'b1;
        wr(8'h03, 8'h08);
        low_volt_cond = 1'b0;
        rd_check("R4 low clear blocked", 8'h03, 8'h08);
        wr(8'h03, 8'h08);
        rd_check("R4 low cleared later", 8'h03, 8'h00);
        high_volt_cond = 1'b1;
        wr(8'h03, 8'h0C);
        high_volt_cond = 1'b0;
        rd_check("R4 high clear blocked", 8'h03, 8'h04);
        wr(8'h03, 8'h04);

        // R5, R6: overcurrent sub-flags and summary
        drv_oc_cond = 1'b1; step(); drv_oc_cond = 1'b0;
        rd_check("R6 drv set", 8'h05, 8'h02);
        rd_check("R5 summary", 8'h03, 8'h02);
        wr(8'h03, 8'h02);
        rd_check("R5 summary not clearable", 8'h05, 8'h02);
        wr(8'h05, 8'h01);
        rd_check("R6 other sub bit", 8'h05, 8'h02);
        bridge_oc_cond = 1'b1; step(); bridge_oc_cond = 1'b0;
        rd_check("R6 both set", 8'h05, 8'h03);
        wr(8'h05, 8'h02);
        rd_check("R6 drv cleared", 8'h05, 8'h01);
        rd_check("R5 summary from bridge", 8'h03, 8'h02);
        bridge_oc_cond = 1'b1;
        wr(8'h05, 8'h01);
        bridge_oc_cond = 1'b0;
        rd_check("R6 bridge clear blocked", 8'h05, 8'h01);
        wr(8'h05, 8'h01);
        rd_check("R6 bridge cleared", 8'h05, 8'h00);
        rd_check("R5 summary clear", 8'h03, 8'h00);

        // R8: sweep all masks against all source patterns
        for (int m = 0; m < 32; m++) begin
            wr(8'h04, 8'(m << 1));
            for (int s = 0; s < 32; s++) begin
                int exp_irq;
                exp_irq = ((s & m) != 0) ? 1 : 0;
                lin_flag_in    = s[4];
                hot_flag_in    = s[3];
                low_volt_cond  = s[2];
                high_volt_cond = s[1];
                drv_oc_cond    = s[0];
                step();
                low_volt_cond  = 1'b0;
                high_volt_cond = 1'b0;
                drv_oc_cond    = 1'b0;
                step();
                check($sformatf("R8 irq m=%0d s=%0d", m, s), int'(irq_req), exp_irq);
                lin_flag_in = 1'b0;
                hot_flag_in = 1'b0;
                wr(8'h03, 8'h0C);
                wr(8'h05, 8'h03);
                step();
                check($sformatf("R8 irq drop m=%0d s=%0d", m, s), int'(irq_req), 0);
            end
        end

        // R1: reset clears everything again
        low_volt_cond = 1'b1; drv_oc_cond = 1'b1; step();
        low_volt_cond = 1'b0; drv_oc_cond = 1'b0;
        wr(8'h04, 8'h3E);
        rst = 1'b1; step(); rst = 1'b0;
        check("R1 irq after reset", int'(irq_req), 0);
        rd_check("R1 stat after reset", 8'h03, 8'h00);
        rd_check("R1 mask after reset", 8'h04, 8'h00);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule